// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register Bank

This block is the register file of an I/O interrupt controller. Software reaches it through two bus addresses. One address holds a register index. The other is a data window onto the register that the index names. The bank holds the following registers:

- an identification register
- a read-only version register that also reports the table size
- an arbitration ID register
- a table of 64-bit routing entries, each seen as two 32-bit halves

Every routing entry drives its fields to the delivery logic as separate output ports: vector, delivery mode, destination mode, polarity, trigger, mask and destination.

The bus port is a simple 32-bit valid/ready port that is always ready. Read data is registered and returned one cycle after the read is accepted. The block checks and reports its own accesses. A window access to an index that names no register changes no state and returns zero. It also raises a one-cycle error pulse.

Top module: `irq_route_regs`

## Requirements
- R1: A write with `req_addr_i`=0 latches `req_wdata_i[7:0]` as the register index, and the upper data bits are ignored. A read with `req_addr_i`=0 returns the index zero-extended to 32 bits. Accesses with `req_addr_i`=1 reach the indexed register.
- R2: `req_ready_o` is always 1. A read accepted at edge k sets `rsp_valid_o` and `rsp_rdata_o` after edge k. `rsp_valid_o` is 0 in any cycle that does not follow an accepted read.
- R3: Index 0x00 stores the ID in bits 31:24. A read returns the ID in bits 31:24 and zeros in all other bits.
- R4: Index 0x01 reads `{8'h00, NUM_ENTRIES-1, 8'h00, VERSION}` (0x00170011 by default). A write to it is ignored and raises no error.
- R5: Index 0x02 stores the arbitration ID from bits 31:24 of the data. A read returns it in bits 31:24 and zeros elsewhere.
- R6: Entry n sits at index 0x10+2n (low half) and at index 0x10+2n+1 (high half). The low half holds the following fields: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, polarity in bit 13, trigger in bit 15 and mask in bit 16. The high half holds the destination in bits 31:24. Each field appears on its output port in the cycle after the write.
- R7: A write to a half clears that half's reserved bits. The low half keeps only mask 0x0001AFFF. The high half keeps only 0xFF000000.
- R8: After reset the following hold: the index, ID and arbitration ID are 0, and every entry has mask=1 with all other bits 0, so its low half reads 0x00010000.
- R9: A window access to an undefined index does three things: it changes no stored value, it returns zero data when it is a read, and it pulses `err_o` for one cycle after the access. The undefined indices are 0x03–0x0F and 0x10+2·NUM_ENTRIES and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Always 1 |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 1 | 0 = index select, 1 = data window |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| err_o | output | 1 | Undefined-index access pulse |
| vector_o | output | NUM_ENTRIES×8 | Per-entry vector |
| dlv_mode_o | output | NUM_ENTRIES×3 | Per-entry delivery mode |
| dst_mode_o | output | NUM_ENTRIES | Per-entry destination mode |
| polarity_o | output | NUM_ENTRIES | Per-entry polarity |
| trigger_o | output | NUM_ENTRIES | Per-entry trigger mode |
| mask_o | output | NUM_ENTRIES | Per-entry mask |
| dest_o | output | NUM_ENTRIES×8 | Per-entry destination |

## Verification
A wrong latched index can show up at the ports in two ways. It makes the next window read return another register's contents one cycle after that read. A window write lands in the wrong entry, whose fields move on the outputs one cycle after the write. Broken reserved-bit clearing shows as set bits on the next read-back of that half. A decode that misses an undefined index shows one cycle later in three ways: `err_o` stays low, a field output moves, or a later read-back of a register that should not have changed returns a different value.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [7:0]  IDX_ID   = 8'h00;
  localparam logic [7:0]  IDX_VER  = 8'h01;
  localparam logic [7:0]  IDX_ARB  = 8'h02;
  localparam logic [7:0]  IDX_TBL  = 8'h10;
  localparam logic [31:0] LO_WMASK = 32'h0001_AFFF;
  localparam logic [31:0] HI_WMASK = 32'hFF00_0000;
  localparam logic [31:0] LO_RST   = 32'h0001_0000;

  typedef enum logic [2:0] {
    REG_ID, REG_VER, REG_ARB, REG_ENT, REG_BAD
  } reg_kind_e;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [7:0]    idx_i,
  output reg_kind_e     kind_o,
  output logic [EW-1:0] ent_o,
  output logic          hi_o
);
  localparam logic [7:0] SPAN = 8'(2 * NUM_ENTRIES);

  logic [7:0] off;
  logic [7:0] ent_full;

  always_comb begin
    off      = idx_i - IDX_TBL;
    ent_full = {1'b0, off[7:1]};
    hi_o     = off[0];
    ent_o    = ent_full[EW-1:0];
    if (idx_i == IDX_ID)                         kind_o = REG_ID;
    else if (idx_i == IDX_VER)                   kind_o = REG_VER;
    else if (idx_i == IDX_ARB)                   kind_o = REG_ARB;
    else if (idx_i >= IDX_TBL && off < SPAN)     kind_o = REG_ENT;
    else                                         kind_o = REG_BAD;
  end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_lo_i,
  input  logic        we_hi_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] lo_o,
  output logic [31:0] hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= LO_RST;
      hi_o <= '0;
    end else begin
      if (we_lo_i) lo_o <= wdata_i & LO_WMASK;
      if (we_hi_i) hi_o <= wdata_i & HI_WMASK;
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         NUM_ENTRIES = 24,
  parameter logic [7:0] VERSION     = 8'h11
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic                         req_write_i,
  input  logic                         req_addr_i,
  input  logic [31:0]                  req_wdata_i,
  output logic                         rsp_valid_o,
  output logic [31:0]                  rsp_rdata_o,
  output logic                         err_o,
  output logic [NUM_ENTRIES-1:0][7:0]  vector_o,
  output logic [NUM_ENTRIES-1:0][2:0]  dlv_mode_o,
  output logic [NUM_ENTRIES-1:0]       dst_mode_o,
  output logic [NUM_ENTRIES-1:0]       polarity_o,
  output logic [NUM_ENTRIES-1:0]       trigger_o,
  output logic [NUM_ENTRIES-1:0]       mask_o,
  output logic [NUM_ENTRIES-1:0][7:0]  dest_o
);
  localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

  logic [7:0]  sel_q;
  logic [7:0]  id_q;
  logic [7:0]  arb_q;
  logic [NUM_ENTRIES-1:0][31:0] ent_lo;
  logic [NUM_ENTRIES-1:0][31:0] ent_hi;

  reg_kind_e     kind;
  logic [EW-1:0] ent;
  logic          half_hi;

  logic wr_sel, wr_win, rd_acc, win_acc;
  logic [31:0] rd_val;

  assign req_ready_o = 1'b1;
  assign win_acc = req_valid_i && req_addr_i;
  assign wr_sel  = req_valid_i && req_write_i && !req_addr_i;
  assign wr_win  = win_acc && req_write_i;
  assign rd_acc  = req_valid_i && !req_write_i;

  irq_route_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_dec (
    .idx_i  (sel_q),
    .kind_o (kind),
    .ent_o  (ent),
    .hi_o   (half_hi)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic hit;
    assign hit = wr_win && (kind == REG_ENT) && (ent == EW'(g));
    irq_route_entry u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_lo_i (hit && !half_hi),
      .we_hi_i (hit && half_hi),
      .wdata_i (req_wdata_i),
      .lo_o    (ent_lo[g]),
      .hi_o    (ent_hi[g])
    );
    assign vector_o[g]   = ent_lo[g][7:0];
    assign dlv_mode_o[g] = ent_lo[g][10:8];
    assign dst_mode_o[g] = ent_lo[g][11];
    assign polarity_o[g] = ent_lo[g][13];
    assign trigger_o[g]  = ent_lo[g][15];
    assign mask_o[g]     = ent_lo[g][16];
    assign dest_o[g]     = ent_hi[g][31:24];
  end

  always_comb begin
    rd_val = '0;
    if (!req_addr_i) begin
      rd_val = {24'h0, sel_q};
    end else begin
      unique case (kind)
        REG_ID:  rd_val = {id_q, 24'h0};
        REG_VER: rd_val = VER_WORD;
        REG_ARB: rd_val = {arb_q, 24'h0};
        REG_ENT: rd_val = half_hi ? ent_hi[ent] : ent_lo[ent];
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= '0;
      id_q        <= '0;
      arb_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      err_o       <= 1'b0;
    end else begin
      if (wr_sel) sel_q <= req_wdata_i[7:0];
      if (wr_win && kind == REG_ID)  id_q  <= req_wdata_i[31:24];
      if (wr_win && kind == REG_ARB) arb_q <= req_wdata_i[31:24];
      rsp_valid_o <= rd_acc;
      rsp_rdata_o <= rd_acc ? rd_val : '0;
      err_o       <= win_acc && (kind == REG_BAD);
    end
  end
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int NUM_ENTRIES = 24
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_valid_i,
  input logic                         req_write_i,
  input logic                         req_addr_i,
  input logic [31:0]                  req_wdata_i,
  input logic                         rsp_valid_o,
  input logic [31:0]                  rsp_rdata_o,
  input logic                         err_o,
  input logic [7:0]                   sel_q,
  input logic [7:0]                   id_q,
  input logic [7:0]                   arb_q,
  input logic [NUM_ENTRIES-1:0][31:0] ent_lo,
  input logic [NUM_ENTRIES-1:0][31:0] ent_hi
);
  logic undef_idx, bad_wr, rsvd_set;

  assign undef_idx = (sel_q >= 8'h03 && sel_q < 8'h10) ||
                     (int'(sel_q) >= 16 + 2 * NUM_ENTRIES);
  assign bad_wr = req_valid_i && req_write_i && req_addr_i && undef_idx;

  always_comb begin
    rsvd_set = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      rsvd_set = rsvd_set || ((ent_lo[i] & ~32'h0001_AFFF) != 0) ||
                             ((ent_hi[i] & ~32'hFF00_0000) != 0);
  end

  assert_sel_latch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !req_addr_i) |=> sel_q == $past(req_wdata_i[7:0]));

  assert_rsp_on_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  assert_no_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);

  assert_rsvd_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsvd_set);

  assert_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_rdata_o == 32'h0);

  assert_bad_wr_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> ($stable(id_q) && $stable(arb_q) && $stable(ent_lo) && $stable(ent_hi)));

  assert_bad_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i && undef_idx) |=> err_o);
endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .err_o       (err_o),
  .sel_q       (sel_q),
  .id_q        (id_q),
  .arb_q       (arb_q),
  .ent_lo      (ent_lo),
  .ent_hi      (ent_hi)
);

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, err;
  logic [31:0] rsp_rdata;
  logic [N-1:0][7:0] vector, dest;
  logic [N-1:0][2:0] dlv_mode;
  logic [N-1:0] dst_mode, polarity, trigger, mask;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_regs #(.NUM_ENTRIES(N), .VERSION(8'h11)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .err_o(err),
    .vector_o(vector), .dlv_mode_o(dlv_mode), .dst_mode_o(dst_mode),
    .polarity_o(polarity), .trigger_o(trigger), .mask_o(mask), .dest_o(dest)
  );

  typedef struct packed {
    logic        wr;
    logic        adr;
    logic [31:0] d;
    logic [31:0] exp;
    logic        eerr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 32'h0000_0000, 32'h0, 1'b0, 4'd1},   // R1 select ID
    '{1'b0, 1'b1, 32'h0,         32'h0, 1'b0, 4'd8},   // R8 ID reset 0
    '{1'b1, 1'b1, 32'hAB12_3456, 32'h0, 1'b0, 4'd3},   // R3
    '{1'b0, 1'b1, 32'h0, 32'hAB00_0000, 1'b0, 4'd3},   // R3 low bits zero
    '{1'b1, 1'b0, 32'hFFFF_FF01, 32'h0, 1'b0, 4'd1},   // R1 upper bits ignored
    '{1'b0, 1'b0, 32'h0, 32'h0000_0001, 1'b0, 4'd1},   // R1 index readback
    '{1'b0, 1'b1, 32'h0, 32'h0017_0011, 1'b0, 4'd4},   // R4 version word
    '{1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd4},   // R4 write ignored, no err
    '{1'b0, 1'b1, 32'h0, 32'h0017_0011, 1'b0, 4'd4},   // R4
    '{1'b1, 1'b0, 32'h0000_0002, 32'h0, 1'b0, 4'd1},
    '{1'b1, 1'b1, 32'h5A00_00FF, 32'h0, 1'b0, 4'd5},   // R5
    '{1'b0, 1'b1, 32'h0, 32'h5A00_0000, 1'b0, 4'd5},   // R5
    '{1'b1, 1'b0, 32'h0000_0010, 32'h0, 1'b0, 4'd1},
    '{1'b0, 1'b1, 32'h0, 32'h0001_0000, 1'b0, 4'd8},   // R8 entry masked
    '{1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd7},   // R7
    '{1'b0, 1'b1, 32'h0, 32'h0001_AFFF, 1'b0, 4'd7},   // R7 low reserved cleared
    '{1'b1, 1'b0, 32'h0000_0011, 32'h0, 1'b0, 4'd1},
    '{1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd7},   // R7
    '{1'b0, 1'b1, 32'h0, 32'hFF00_0000, 1'b0, 4'd7},   // R7 high reserved cleared
    '{1'b1, 1'b0, 32'h0000_003F, 32'h0, 1'b0, 4'd6},   // R6 last entry high
    '{1'b1, 1'b1, 32'h8100_0000, 32'h0, 1'b0, 4'd6},
    '{1'b0, 1'b1, 32'h0, 32'h8100_0000, 1'b0, 4'd6},   // R6
    '{1'b1, 1'b0, 32'h0000_003E, 32'h0, 1'b0, 4'd6},   // R6 last entry low
    '{1'b1, 1'b1, 32'h0000_A531, 32'h0, 1'b0, 4'd6},
    '{1'b0, 1'b1, 32'h0, 32'h0000_A531, 1'b0, 4'd6},   // R6
    '{1'b1, 1'b0, 32'h0000_0005, 32'h0, 1'b0, 4'd1},
    '{1'b0, 1'b1, 32'h0, 32'h0,         1'b1, 4'd9},   // R9 read of gap
    '{1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b1, 4'd9},   // R9 write of gap
    '{1'b1, 1'b0, 32'h0000_0040, 32'h0, 1'b0, 4'd1},
    '{1'b0, 1'b1, 32'h0, 32'h0,         1'b1, 4'd9},   // R9 past table end
    '{1'b1, 1'b0, 32'h0000_000F, 32'h0, 1'b0, 4'd1},
    '{1'b1, 1'b1, 32'h1234_5678, 32'h0, 1'b1, 4'd9},   // R9
    '{1'b1, 1'b0, 32'h0000_003E, 32'h0, 1'b0, 4'd1},
    '{1'b0, 1'b1, 32'h0, 32'h0000_A531, 1'b0, 4'd9},   // R9 entry untouched
    '{1'b1, 1'b0, 32'h0000_0000, 32'h0, 1'b0, 4'd1},
    '{1'b0, 1'b1, 32'h0, 32'hAB00_0000, 1'b0, 4'd9},   // R9 ID untouched
    '{1'b0, 1'b0, 32'h0, 32'h0000_0000, 1'b0, 4'd1}    // R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic access(input vec_t v);
    @(negedge clk);
    req_valid = 1; req_write = v.wr; req_addr = v.adr; req_wdata = v.d;
    check($sformatf("R2 ready (req R%0d)", v.req), 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 0;
    check($sformatf("R2 rsp_valid (req R%0d)", v.req), 32'(rsp_valid), 32'(!v.wr));
    check($sformatf("R%0d err", v.req), 32'(err), 32'(v.eerr));
    if (!v.wr) check($sformatf("R%0d rdata", v.req), rsp_rdata, v.exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R8 reset state
    check("R8 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R8 err", 32'(err), 32'd0);
    check("R8 all masked", 32'(&mask), 32'd1);
    check("R8 vector0", 32'(vector[0]), 32'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) access(TBL[i]);
    // R6 fields of last entry: vector 0x31, mode 5, trig 1, pol 1, mask 0, dest 0x81
    check("R6 vector23", 32'(vector[N-1]), 32'h31);
    check("R6 dlv23", 32'(dlv_mode[N-1]), 32'd5);
    check("R6 dstmode23", 32'(dst_mode[N-1]), 32'd0);
    check("R6 pol23", 32'(polarity[N-1]), 32'd1);
    check("R6 trig23", 32'(trigger[N-1]), 32'd1);
    check("R6 mask23", 32'(mask[N-1]), 32'd0);
    check("R6 dest23", 32'(dest[N-1]), 32'h81);
    // R7 entry 0 after all-ones writes
    check("R7 vector0", 32'(vector[0]), 32'hFF);
    check("R7 dlv0", 32'(dlv_mode[0]), 32'd7);
    check("R7 dest0", 32'(dest[0]), 32'hFF);
    check("R8 entry1 still masked", 32'(mask[1]), 32'd1);
    check("R8 entry1 dest", 32'(dest[1]), 32'd0);
    // R2 response lasts one cycle only
    @(negedge clk);
    check("R2 rsp idle", 32'(rsp_valid), 32'd0);
    check("R9 err idle", 32'(err), 32'd0);
    summary();
  end
endmodule